// File: doc/BRIEF.md
# Standby/Operate Power Sequencer

This block stages the switch of a power amplifier between standby and operate. A prescaler divides the system clock into a single-cycle step enable, nominally once every 10 ms. A four-stage bidirectional shift register advances one stage per step. When it is powering up, ones enter at the first stage and move toward the last, so the enables come on one at a time. When it is powering down, zeros enter at the last stage and move back toward the first, so the enables go off in the reverse order.

A direction register chooses which way the register shifts. It samples the operate command on each step. A reset command clears it toward standby at once. Leaving remote control for local control fires a short one-shot reset pulse, which has the same effect as the reset command. Status outputs flag the two resting patterns: all stages on, and all stages off. The remote and lockout flags are registered copies of their request inputs, and no reset source touches them.

Top module: `standby_operate_sequencer`

## Requirements
- R1: `step_tick` is high for exactly one cycle in every STEP_DIV cycles. The first high cycle is the STEP_DIV-th cycle after the internal reset is released.
- R2: `stage_en` bit 0 is the first stage. `operate_status` is high only when `stage_en` is all ones. `standby_status` is high only when `stage_en` is all zeros.
- R3: The direction register loads `operate_cmd` only on an edge where `step_tick` is high. `mode_sel` is written {S1,S0}: 2'b01 means shift toward operate, and 2'b10 means shift toward standby.
- R4: On a step edge in mode 2'b01, a one enters bit 0 and every bit takes the value of the bit below it. Between step edges `stage_en` holds.
- R5: On a step edge in mode 2'b10, a zero enters bit 3 and every bit takes the value of the bit above it. Once `stage_en` reaches all zeros it stays there while the mode is 2'b10.
- R6: A change of direction partway through a sequence shifts on from the current pattern, with no restart.
- R7: On any edge where `seq_reset_cmd` or `local_reset_pulse` is high, the direction register is cleared to standby (mode 2'b10). This holds whether or not a step falls on that edge, and the clear wins over `operate_cmd`.
- R8: On the edge where `remote_flag` falls from 1 to 0, `local_reset_pulse` rises. It then stays high for exactly PULSE_CYCLES cycles.
- R9: `remote_flag` and `lockout_flag` follow `remote_req` and `lockout_req` one cycle later. Neither `seq_reset_cmd` nor `local_reset_pulse` changes them.
- R10: While `rst_n` is low, `stage_en` is 0, the mode is 2'b10, and both flags, the pulse and the prescaler are cleared. The internal reset is released on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| operate_cmd | input | 1 | 1 requests operate, 0 requests standby |
| seq_reset_cmd | input | 1 | Reset command, clears the direction toward standby |
| remote_req | input | 1 | 1 while the unit is under remote control |
| lockout_req | input | 1 | Local lockout request |
| step_tick | output | 1 | Single-cycle step enable |
| mode_sel | output | 2 | Shift mode {S1,S0} |
| stage_en | output | 4 | Sequenced stage enables, bit 0 first |
| operate_status | output | 1 | All stages on |
| standby_status | output | 1 | All stages off |
| local_reset_pulse | output | 1 | One-shot pulse raised on a remote-to-local change |
| remote_flag | output | 1 | Registered remote state |
| lockout_flag | output | 1 | Registered lockout state |

## Verification
A reset, whether from the command or from the local one-shot, can land on the same edge as a step that would load an operate request into the direction register. The bench creates this collision on purpose. It waits until `step_tick` is high, which means the next edge is a step edge, and on that cycle raises `operate_cmd` and `seq_reset_cmd` together. It then requires `mode_sel` to read standby afterwards. A long pseudo-random phase with a short divider also lands one-shot pulses and reversals on step edges. Every cycle of that phase is judged against an arithmetic model of the register's contents kept in the bench.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Shift mode, written {S1,S0}
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,  // toward operate: ones enter at stage 0
    MODE_SHL  = 2'b10,  // toward standby: zeros enter at the top stage
    MODE_IDLE = 2'b11   // unused, treated as hold
  } seq_mode_e;
endpackage

// File: rtl/seq_step_prescaler.sv
module seq_step_prescaler #(
  parameter int unsigned STEP_DIV = 1_250_000
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (STEP_DIV > 1) begin : g_chk
      assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/seq_link_flags.sv
module seq_link_flags #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic remote_req_i,
  input  logic lockout_req_i,
  output logic remote_flag_o,
  output logic lockout_flag_o,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);

  logic          remote_q, lockout_q;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          going_local;

  assign going_local = remote_q & ~remote_req_i;

  always_comb begin
    if (going_local)        pcnt_d = LOAD;
    else if (pcnt_q != '0)  pcnt_d = pcnt_q - 1'b1;
    else                    pcnt_d = pcnt_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      remote_q  <= 1'b0;
      lockout_q <= 1'b0;
      pcnt_q    <= '0;
    end else begin
      remote_q  <= remote_req_i;
      lockout_q <= lockout_req_i;
      pcnt_q    <= pcnt_d;
    end
  end

  assign remote_flag_o  = remote_q;
  assign lockout_flag_o = lockout_q;
  assign pulse_o        = (pcnt_q != '0);

  assert_pulse_on_local_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(remote_q) |-> pulse_o);
endmodule

// File: rtl/seq_direction.sv
module seq_direction
  import seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      clear_i,
  input  logic      tick_i,
  input  logic      operate_cmd_i,
  output seq_mode_e mode_o
);
  logic dir_q, dir_d;

  always_comb begin
    if (clear_i)     dir_d = 1'b0;
    else if (tick_i) dir_d = operate_cmd_i;
    else             dir_d = dir_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_d;
  end

  assign mode_o = dir_q ? MODE_SHR : MODE_SHL;

  assert_clear_standby_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    clear_i |=> (mode_o == MODE_SHL));
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_i && !tick_i) |=> $stable(mode_o));
endmodule

// File: rtl/seq_shift_stages.sv
module seq_shift_stages
  import seq_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  seq_mode_e         mode_i,
  output logic [STAGES-1:0] q_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] q_q, q_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_first
      assign from_low = 1'b1;
    end else begin : g_mid_lo
      assign from_low = q_q[i-1];
    end
    if (i == TOP) begin : g_last
      assign from_high = 1'b0;
    end else begin : g_mid_hi
      assign from_high = q_q[i+1];
    end
    assign q_d[i] = (mode_i == MODE_SHR) ? from_low  :
                    (mode_i == MODE_SHL) ? from_high : q_q[i];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (tick_i) q_q <= q_d;
  end

  assign q_o = q_q;

  assert_one_enters_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_SHR) |=> q_o[0]);
  assert_zero_enters_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_SHL) |=> !q_o[TOP]);
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick_i |=> $stable(q_o));
endmodule

// File: rtl/standby_operate_sequencer.sv
module standby_operate_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned STEP_DIV     = 1_250_000,
  parameter int unsigned PULSE_CYCLES = 4,
  parameter int unsigned STAGES       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              operate_cmd,
  input  logic              seq_reset_cmd,
  input  logic              remote_req,
  input  logic              lockout_req,
  output logic              step_tick,
  output logic [1:0]        mode_sel,
  output logic [STAGES-1:0] stage_en,
  output logic              operate_status,
  output logic              standby_status,
  output logic              local_reset_pulse,
  output logic              remote_flag,
  output logic              lockout_flag
);
  logic      rst_meta_q, rst_int_n;
  logic      tick, pulse, clear;
  seq_mode_e mode;

  // reset: asserted asynchronously, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  seq_step_prescaler #(.STEP_DIV(STEP_DIV)) u_presc (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .tick_o (tick)
  );

  seq_link_flags #(.PULSE_CYCLES(PULSE_CYCLES)) u_flags (
    .clk            (clk),
    .rst_ni         (rst_int_n),
    .remote_req_i   (remote_req),
    .lockout_req_i  (lockout_req),
    .remote_flag_o  (remote_flag),
    .lockout_flag_o (lockout_flag),
    .pulse_o        (pulse)
  );

  assign clear = seq_reset_cmd | pulse;

  seq_direction u_dir (
    .clk           (clk),
    .rst_ni        (rst_int_n),
    .clear_i       (clear),
    .tick_i        (tick),
    .operate_cmd_i (operate_cmd),
    .mode_o        (mode)
  );

  seq_shift_stages #(.STAGES(STAGES)) u_stages (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .tick_i (tick),
    .mode_i (mode),
    .q_o    (stage_en)
  );

  assign step_tick         = tick;
  assign mode_sel          = mode;
  assign local_reset_pulse = pulse;
  assign operate_status    = &stage_en;
  assign standby_status    = ~|stage_en;

  assert_flags_ignore_reset_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clear && $stable(remote_req) && $stable(lockout_req))
      |=> (remote_flag == $past(remote_flag) && lockout_flag == $past(lockout_flag)));
  assert_status_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(operate_status && standby_status));
endmodule

// File: tb/standby_operate_sequencer_test.sv
module standby_operate_sequencer_test;
  localparam int DIV = 4;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic operate_cmd = 1'b0, seq_reset_cmd = 1'b0, remote_req = 1'b0, lockout_req = 1'b0;
  logic step_tick, operate_status, standby_status, local_reset_pulse, remote_flag, lockout_flag;
  logic [1:0] mode_sel;
  logic [3:0] stage_en;

  int checks = 0, fails = 0, cycles = 0;
  bit chk_en = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  standby_operate_sequencer #(.STEP_DIV(DIV), .PULSE_CYCLES(PULSE), .STAGES(4)) uut (
    .clk(clk), .rst_n(rst_n), .operate_cmd(operate_cmd), .seq_reset_cmd(seq_reset_cmd),
    .remote_req(remote_req), .lockout_req(lockout_req), .step_tick(step_tick),
    .mode_sel(mode_sel), .stage_en(stage_en), .operate_status(operate_status),
    .standby_status(standby_status), .local_reset_pulse(local_reset_pulse),
    .remote_flag(remote_flag), .lockout_flag(lockout_flag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // bench model, built from the requirements
  logic [1:0] m_rs;
  int         m_cnt, m_pc;
  logic       m_rem, m_lock, m_dir;
  logic [3:0] m_st;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_rs <= 2'b00; m_cnt <= 0; m_pc <= 0; m_rem <= 0; m_lock <= 0; m_dir <= 0; m_st <= 4'h0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin
        m_cnt  <= (m_cnt == DIV-1) ? 0 : m_cnt + 1;
        m_rem  <= remote_req;
        m_lock <= lockout_req;
        if (m_rem && !remote_req) m_pc <= PULSE;
        else if (m_pc != 0)       m_pc <= m_pc - 1;
        if (seq_reset_cmd || m_pc != 0) m_dir <= 1'b0;
        else if (m_cnt == DIV-1)        m_dir <= operate_cmd;
        if (m_cnt == DIV-1) begin
          if (m_dir) m_st <= {m_st[2:0], 1'b1};
          else       m_st <= {1'b0, m_st[3:1]};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R1 step_tick", 8'(step_tick), 8'(m_cnt == DIV-1));
      chk("R3/R7 mode_sel", 8'(mode_sel), m_dir ? 8'h01 : 8'h02);
      chk("R4/R5/R6 stage_en", 8'(stage_en), 8'(m_st));
      chk("R2 operate_status", 8'(operate_status), 8'(m_st == 4'hF));
      chk("R2 standby_status", 8'(standby_status), 8'(m_st == 4'h0));
      chk("R8 local_reset_pulse", 8'(local_reset_pulse), 8'(m_pc != 0));
      chk("R9 flags", {6'd0, remote_flag, lockout_flag}, {6'd0, m_rem, m_lock});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    logic [15:0] lfsr;
    int seen;
    logic [3:0] prev;
    lfsr = 16'hACE1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 stage_en in reset", 8'(stage_en), 8'h0);
    chk("R10 mode in reset", 8'(mode_sel), 8'h02);
    chk("R10 standby_status in reset", 8'(standby_status), 8'h1);
    chk("R10 pulse in reset", 8'(local_reset_pulse), 8'h0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R4: power-up order 1,3,7,F
    operate_cmd = 1'b1;
    prev = 4'h0; seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stage_en != prev) begin
        case (seen)
          0: chk("R4 first stage", 8'(stage_en), 8'h1);
          1: chk("R4 second stage", 8'(stage_en), 8'h3);
          2: chk("R4 third stage", 8'(stage_en), 8'h7);
          default: chk("R4 fourth stage", 8'(stage_en), 8'hF);
        endcase
        seen++; prev = stage_en;
      end
    end
    chk("R4 power-up steps", 8'(seen), 8'd4);
    // R5: power-down order 7,3,1,0
    operate_cmd = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stage_en != prev) begin
        case (seen)
          0: chk("R5 first off", 8'(stage_en), 8'h7);
          1: chk("R5 second off", 8'(stage_en), 8'h3);
          2: chk("R5 third off", 8'(stage_en), 8'h1);
          default: chk("R5 all off", 8'(stage_en), 8'h0);
        endcase
        seen++; prev = stage_en;
      end
    end
    chk("R5 power-down steps", 8'(seen), 8'd4);

    // R7: reset command and operate request on the same step edge
    while (step_tick !== 1'b1) @(negedge clk);
    operate_cmd = 1'b1; seq_reset_cmd = 1'b1;
    @(negedge clk);
    seq_reset_cmd = 1'b0;
    chk("R7 clear beats step", 8'(mode_sel), 8'h02);

    // R8/R9: remote to local
    remote_req = 1'b1; lockout_req = 1'b1;
    repeat (3) @(negedge clk);
    remote_req = 1'b0;
    @(negedge clk);
    seen = 0;
    while (local_reset_pulse === 1'b1 && seen < 20) begin
      chk("R9 lockout kept during pulse", 8'(lockout_flag), 8'h1);
      seen++;
      @(negedge clk);
    end
    chk("R8 pulse length", 8'(seen), 8'(PULSE));
    chk("R7 pulse cleared direction", 8'(mode_sel), 8'h02);
    lockout_req = 1'b0;

    // pseudo-random sweep: reversals, collisions, pulses
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4:0] == 5'd0)  operate_cmd = ~operate_cmd;
      seq_reset_cmd = (lfsr[10:5] == 6'd0);
      if (lfsr[12:8] == 5'd5) remote_req = ~remote_req;
      lockout_req = lfsr[15];
      if (n == 3000) begin
        chk_en = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 async clear", 8'(stage_en), 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;
      end
    end
    finish_run();
  end
endmodule